// File: doc/BRIEF.md
# SMBus Alert and Address Selector

This block sits beside an SMBus/PMBus target engine. It forms the device's bus address from two 3-bit strap digits. It latches status conditions and drives the active-low alert line when a condition arrives. It also tells the target engine whether to acknowledge the address header it has just received. The address header is presented in the same cycle and the acknowledge decision is combinational.

A mode bit in the configuration word selects how an active alert is handled. With the bit clear, the device keeps answering its strapped address and ignores the Alert Response Address (ARA, 7-bit 0x0C). The host then finds the cause through status reads and retires the alert with a clear-faults command. With the bit set, an active alert makes the device answer only the ARA. A completed receive-byte from the ARA returns the device's address byte and releases the alert. After that release, the strapped address is answered again. No arbitration between several ARA responders is done.

Top module: `smb_alert_addr_sel`

## Requirements
- R1: With both strap digits flagged valid, `dev_addr_o` is `{1'b0, strap_hi_i, strap_lo_i}` (high digit in bits 5:3, low digit in bits 2:0), covering 0 to 63.
- R2: If either strap validity flag is low, `dev_addr_o` is 127.
- R3: Any bit high on `cond_set_i` is latched into the same bit of `cond_o`, and `alert_no` is low from the following clock edge on.
- R4: A `clear_faults_i` pulse zeroes `cond_o` and drives `alert_no` high at the next edge. A condition bit set in the same cycle is kept, and in that case the alert stays asserted.
- R5: With `cfg_i` bit 4 = 0, the strapped address is acknowledged whether or not the alert is active. The ARA 0x0C is not acknowledged unless it is the strapped address, and `ara_rd_done_i` has no effect on the alert.
- R6: With `cfg_i` bit 4 = 1 and the alert active, only address 0x0C is acknowledged, and the strapped address is not.
- R7: With `cfg_i` bit 4 = 1 and the alert active, an `ara_rd_done_i` pulse drives `alert_no` high at the next edge. `cond_o` is left unchanged, and the strapped address is acknowledged again.
- R8: `ara_byte_o` always equals `{dev_addr_o, 1'b0}`.
- R9: `addr_rsvd_o` is high when the strapped address is valid and is one of 0 to 12, 40, 44, 45 or 55. These addresses are still decoded and acknowledged. The flag is low for the fallback address 127.
- R10: After the alert has been released by either means, a new condition asserts `alert_no` low again at the next edge.
- R11: `ack_o` is low whenever `hdr_valid_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_hi_i | input | 3 | High octal address digit |
| strap_hi_ok_i | input | 1 | High digit is in range |
| strap_lo_i | input | 3 | Low octal address digit |
| strap_lo_ok_i | input | 1 | Low digit is in range |
| cfg_i | input | 8 | Configuration word; bit 4 selects ARA mode |
| cond_set_i | input | 8 | Status condition events, one per bit |
| clear_faults_i | input | 1 | Clear-faults command strobe |
| hdr_valid_i | input | 1 | Address header presented by target engine |
| hdr_addr_i | input | 7 | 7-bit address of that header |
| ara_rd_done_i | input | 1 | Receive-byte from ARA completed |
| ack_o | output | 1 | Acknowledge the presented header |
| dev_addr_o | output | 7 | Effective strapped device address |
| addr_rsvd_o | output | 1 | Strapped address lies in a reserved slot |
| ara_byte_o | output | 8 | Byte returned on an ARA read |
| cond_o | output | 8 | Latched status conditions |
| alert_no | output | 1 | Alert line, active low |

## Verification
The bench strikes the address swap in both modes. A design that ignores the mode bit would go silent on its strapped address during an alert, or would answer 0x0C in default mode. The bench pulses `ara_rd_done_i` in default mode, where a wrong design would drop the alert without a clear. It also sets a condition in the same cycle as clear-faults, where a design that lets clear win would lose the event. The strap flags are driven invalid one at a time, and the reserved boundaries 12/13 and 44/45/46 are walked, so an off-by-one decode or a fallback tied to only one flag shows up as a wrong address or flag.

// File: rtl/smb_alert_pkg.sv
package smb_alert_pkg;
  localparam int unsigned ADDR_W = 7;

  typedef logic [ADDR_W-1:0] smb_addr_t;

  localparam smb_addr_t ARA_ADDR      = 7'h0C;
  localparam smb_addr_t FALLBACK_ADDR = 7'h7F;

  function automatic logic is_rsvd(input smb_addr_t a);
    return (a <= 7'd12) || (a == 7'd40) || (a == 7'd44) ||
           (a == 7'd45) || (a == 7'd55);
  endfunction
endpackage

// File: rtl/smb_addr_build.sv
module smb_addr_build
  import smb_alert_pkg::*;
#(
  parameter int unsigned DIG_W = 3
) (
  input  logic [DIG_W-1:0] hi_i,
  input  logic             hi_ok_i,
  input  logic [DIG_W-1:0] lo_i,
  input  logic             lo_ok_i,
  output smb_addr_t        addr_o,
  output logic             rsvd_o
);
  localparam int unsigned STRAP_W = 2 * DIG_W;
  localparam int unsigned PAD_W   = ADDR_W - STRAP_W;

  logic [1:0] ok_vec;
  logic       all_ok;
  smb_addr_t  strap_addr;

  assign ok_vec     = {hi_ok_i, lo_ok_i};
  assign all_ok     = &ok_vec;
  assign strap_addr = {{PAD_W{1'b0}}, hi_i, lo_i};
  assign addr_o     = all_ok ? strap_addr : FALLBACK_ADDR;
  assign rsvd_o     = all_ok && is_rsvd(strap_addr);
endmodule

// File: rtl/smb_alert_ctrl.sv
module smb_alert_ctrl #(
  parameter int unsigned N_COND = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_COND-1:0] cond_set_i,
  input  logic              clear_i,
  input  logic              ara_mode_i,
  input  logic              ara_done_i,
  output logic [N_COND-1:0] cond_o,
  output logic              alert_o
);
  logic [N_COND-1:0] cond_q;
  logic              alert_q;
  logic              any_set;
  logic              release_req;

  for (genvar i = 0; i < N_COND; i++) begin : g_cond
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cond_q[i] <= 1'b0;
      else if (cond_set_i[i])   cond_q[i] <= 1'b1; // set beats clear
      else if (clear_i)         cond_q[i] <= 1'b0;
    end
  end

  assign any_set     = |cond_set_i;
  assign release_req = clear_i || (ara_mode_i && alert_q && ara_done_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          alert_q <= 1'b0;
    else if (any_set)     alert_q <= 1'b1;
    else if (release_req) alert_q <= 1'b0;
  end

  assign cond_o  = cond_q;
  assign alert_o = alert_q;
endmodule

// File: rtl/smb_resp_match.sv
module smb_resp_match
  import smb_alert_pkg::*;
(
  input  logic      hdr_valid_i,
  input  smb_addr_t hdr_addr_i,
  input  smb_addr_t dev_addr_i,
  input  logic      ara_mode_i,
  input  logic      alert_i,
  output logic      ack_o
);
  logic swapped;
  logic hit_dev;
  logic hit_ara;

  // only one address is live at a time
  assign swapped = ara_mode_i && alert_i;
  assign hit_dev = (hdr_addr_i == dev_addr_i) && !swapped;
  assign hit_ara = (hdr_addr_i == ARA_ADDR) && swapped;
  assign ack_o   = hdr_valid_i && (hit_dev || hit_ara);
endmodule

// File: rtl/smb_alert_addr_sel.sv
module smb_alert_addr_sel
  import smb_alert_pkg::*;
#(
  parameter int unsigned DIG_W   = 3,
  parameter int unsigned N_COND  = 8,
  parameter int unsigned CFG_W   = 8,
  parameter int unsigned ARA_BIT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIG_W-1:0]  strap_hi_i,
  input  logic              strap_hi_ok_i,
  input  logic [DIG_W-1:0]  strap_lo_i,
  input  logic              strap_lo_ok_i,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic [N_COND-1:0] cond_set_i,
  input  logic              clear_faults_i,
  input  logic              hdr_valid_i,
  input  logic [6:0]        hdr_addr_i,
  input  logic              ara_rd_done_i,
  output logic              ack_o,
  output logic [6:0]        dev_addr_o,
  output logic              addr_rsvd_o,
  output logic [7:0]        ara_byte_o,
  output logic [N_COND-1:0] cond_o,
  output logic              alert_no
);
  smb_addr_t dev_addr;
  logic      ara_mode;
  logic      alert;

  assign ara_mode = cfg_i[ARA_BIT];

  smb_addr_build #(.DIG_W(DIG_W)) u_addr (
    .hi_i    (strap_hi_i),
    .hi_ok_i (strap_hi_ok_i),
    .lo_i    (strap_lo_i),
    .lo_ok_i (strap_lo_ok_i),
    .addr_o  (dev_addr),
    .rsvd_o  (addr_rsvd_o)
  );

  smb_alert_ctrl #(.N_COND(N_COND)) u_alert (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cond_set_i (cond_set_i),
    .clear_i    (clear_faults_i),
    .ara_mode_i (ara_mode),
    .ara_done_i (ara_rd_done_i),
    .cond_o     (cond_o),
    .alert_o    (alert)
  );

  smb_resp_match u_match (
    .hdr_valid_i (hdr_valid_i),
    .hdr_addr_i  (hdr_addr_i),
    .dev_addr_i  (dev_addr),
    .ara_mode_i  (ara_mode),
    .alert_i     (alert),
    .ack_o       (ack_o)
  );

  assign dev_addr_o = dev_addr;
  assign ara_byte_o = {dev_addr, 1'b0};
  assign alert_no   = ~alert;
endmodule

// File: rtl/smb_alert_addr_sel_chk.sv
module smb_alert_addr_sel_chk #(
  parameter int unsigned N_COND  = 8,
  parameter int unsigned CFG_W   = 8,
  parameter int unsigned ARA_BIT = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              strap_hi_ok_i,
  input logic              strap_lo_ok_i,
  input logic [CFG_W-1:0]  cfg_i,
  input logic [N_COND-1:0] cond_set_i,
  input logic              clear_faults_i,
  input logic              hdr_valid_i,
  input logic [6:0]        hdr_addr_i,
  input logic              ara_rd_done_i,
  input logic              ack_o,
  input logic [6:0]        dev_addr_o,
  input logic [7:0]        ara_byte_o,
  input logic [N_COND-1:0] cond_o,
  input logic              alert_no
);
  AST_FALLBACK_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(strap_hi_ok_i && strap_lo_ok_i) |-> dev_addr_o == 7'h7F); // R2
  AST_ALERT_ON_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cond_set_i) |=> !alert_no); // R3
  AST_CLEAR_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_faults_i && cond_set_i == '0) |=> (alert_no && cond_o == '0)); // R4
  AST_DEFAULT_NO_ARA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_i[ARA_BIT] && hdr_valid_i && hdr_addr_i == 7'h0C && dev_addr_o != 7'h0C) |-> !ack_o); // R5
  AST_DEFAULT_KEEP_ALERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_i[ARA_BIT] && !alert_no && !clear_faults_i) |=> !alert_no); // R5
  AST_ARA_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i[ARA_BIT] && !alert_no && hdr_valid_i && hdr_addr_i != 7'h0C) |-> !ack_o); // R6
  AST_ARA_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i[ARA_BIT] && !alert_no && ara_rd_done_i && cond_set_i == '0) |=> alert_no); // R7
  AST_ARA_KEEP_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ara_rd_done_i && !clear_faults_i && cond_set_i == '0) |=> $stable(cond_o)); // R7
  AST_ARA_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ara_byte_o == {dev_addr_o, 1'b0}); // R8
  AST_NO_ACK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hdr_valid_i |-> !ack_o); // R11
endmodule

bind smb_alert_addr_sel smb_alert_addr_sel_chk #(
  .N_COND(N_COND), .CFG_W(CFG_W), .ARA_BIT(ARA_BIT)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .strap_hi_ok_i  (strap_hi_ok_i),
  .strap_lo_ok_i  (strap_lo_ok_i),
  .cfg_i          (cfg_i),
  .cond_set_i     (cond_set_i),
  .clear_faults_i (clear_faults_i),
  .hdr_valid_i    (hdr_valid_i),
  .hdr_addr_i     (hdr_addr_i),
  .ara_rd_done_i  (ara_rd_done_i),
  .ack_o          (ack_o),
  .dev_addr_o     (dev_addr_o),
  .ara_byte_o     (ara_byte_o),
  .cond_o         (cond_o),
  .alert_no       (alert_no)
);

// File: tb/smb_alert_addr_sel_bench.sv
module smb_alert_addr_sel_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] strap_hi_i = '0, strap_lo_i = '0;
  logic       strap_hi_ok_i = 1'b1, strap_lo_ok_i = 1'b1;
  logic [7:0] cfg_i = '0;
  logic [7:0] cond_set_i = '0;
  logic       clear_faults_i = 1'b0;
  logic       hdr_valid_i = 1'b0;
  logic [6:0] hdr_addr_i = '0;
  logic       ara_rd_done_i = 1'b0;
  logic       ack_o, addr_rsvd_o, alert_no;
  logic [6:0] dev_addr_o;
  logic [7:0] ara_byte_o, cond_o;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  smb_alert_addr_sel u_smb_alert_addr_sel (.*);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at negedge, let one posedge pass, sample at the next negedge
  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic probe(input logic [6:0] a, output int ack);
    hdr_valid_i = 1'b1;
    hdr_addr_i  = a;
    #1 ack = int'(ack_o);
    hdr_valid_i = 1'b0;
  endtask

  task automatic set_straps(input int hi, input int lo);
    strap_hi_i = 3'(hi);
    strap_lo_i = 3'(lo);
    #1;
  endtask

  task automatic pulse_cond(input logic [7:0] v);
    cond_set_i = v;
    step();
    cond_set_i = '0;
  endtask

  task automatic t_reset();
    chk("R3 reset alert", int'(alert_no), 1);
    chk("R3 reset cond", int'(cond_o), 0);
  endtask

  task automatic t_addr();
    int ack;
    set_straps(5, 3);
    chk("R1 addr 53o", int'(dev_addr_o), 43);
    chk("R8 ara byte", int'(ara_byte_o), 86);
    set_straps(7, 7);
    chk("R1 addr 77o", int'(dev_addr_o), 63);
    probe(7'd63, ack);
    chk("R1 ack strapped", ack, 1);
    probe(7'd62, ack);
    chk("R1 no ack other", ack, 0);
    hdr_addr_i = 7'd63;
    #1 chk("R11 no ack without valid", int'(ack_o), 0);
  endtask

  task automatic t_fallback();
    int ack;
    set_straps(2, 6);
    strap_hi_ok_i = 1'b0;
    #1 chk("R2 hi invalid", int'(dev_addr_o), 127);
    chk("R8 fallback byte", int'(ara_byte_o), 254);
    chk("R9 fallback not rsvd", int'(addr_rsvd_o), 0);
    probe(7'd127, ack);
    chk("R2 ack 127", ack, 1);
    probe(7'd22, ack);
    chk("R2 no ack strap", ack, 0);
    strap_hi_ok_i = 1'b1;
    strap_lo_ok_i = 1'b0;
    #1 chk("R2 lo invalid", int'(dev_addr_o), 127);
    strap_lo_ok_i = 1'b1;
    #1 chk("R1 restored", int'(dev_addr_o), 22);
  endtask

  task automatic t_rsvd();
    int ack;
    for (int a = 0; a < 64; a++) begin
      int exp;
      exp = (a <= 12 || a == 40 || a == 44 || a == 45 || a == 55) ? 1 : 0;
      set_straps(a / 8, a % 8);
      chk($sformatf("R9 rsvd %0d", a), int'(addr_rsvd_o), exp);
    end
    set_straps(1, 4); // 12
    probe(7'd12, ack);
    chk("R9 reserved still decoded", ack, 1);
  endtask

  task automatic t_clear();
    set_straps(4, 2);
    cfg_i = 8'h00;
    pulse_cond(8'h05);
    chk("R3 alert low", int'(alert_no), 0);
    chk("R3 cond latched", int'(cond_o), 5);
    pulse_cond(8'h20);
    chk("R3 cond accumulates", int'(cond_o), 8'h25);
    clear_faults_i = 1'b1;
    step();
    clear_faults_i = 1'b0;
    chk("R4 clear alert", int'(alert_no), 1);
    chk("R4 clear cond", int'(cond_o), 0);
    clear_faults_i = 1'b1;
    cond_set_i = 8'h80;
    step();
    clear_faults_i = 1'b0;
    cond_set_i = '0;
    chk("R4 set wins alert", int'(alert_no), 0);
    chk("R4 set wins cond", int'(cond_o), 8'h80);
    clear_faults_i = 1'b1;
    step();
    clear_faults_i = 1'b0;
    pulse_cond(8'h02);
    chk("R10 reassert after clear", int'(alert_no), 0);
    clear_faults_i = 1'b1;
    step();
    clear_faults_i = 1'b0;
  endtask

  task automatic t_default_mode();
    int ack;
    cfg_i = 8'hEF; // all bits but 4
    set_straps(4, 2); // 34
    pulse_cond(8'h01);
    probe(7'd34, ack);
    chk("R5 strapped during alert", ack, 1);
    probe(7'h0C, ack);
    chk("R5 ara ignored", ack, 0);
    ara_rd_done_i = 1'b1;
    step();
    ara_rd_done_i = 1'b0;
    chk("R5 ara done no effect", int'(alert_no), 0);
    chk("R5 cond kept", int'(cond_o), 1);
    clear_faults_i = 1'b1;
    step();
    clear_faults_i = 1'b0;
    chk("R5 clear releases", int'(alert_no), 1);
  endtask

  task automatic t_ara_mode();
    int ack;
    cfg_i = 8'h10;
    set_straps(4, 2); // 34
    probe(7'd34, ack);
    chk("R6 strapped before alert", ack, 1);
    probe(7'h0C, ack);
    chk("R6 no ara before alert", ack, 0);
    pulse_cond(8'h40);
    probe(7'd34, ack);
    chk("R6 strapped silent", ack, 0);
    probe(7'h0C, ack);
    chk("R6 ara acked", ack, 1);
    chk("R8 returned byte", int'(ara_byte_o), 68);
    ara_rd_done_i = 1'b1;
    step();
    ara_rd_done_i = 1'b0;
    chk("R7 alert released", int'(alert_no), 1);
    chk("R7 cond kept", int'(cond_o), 8'h40);
    probe(7'd34, ack);
    chk("R7 strapped back", ack, 1);
    probe(7'h0C, ack);
    chk("R7 ara dropped", ack, 0);
    pulse_cond(8'h08);
    chk("R10 reassert after ara", int'(alert_no), 0);
    probe(7'h0C, ack);
    chk("R10 ara live again", ack, 1);
    clear_faults_i = 1'b1;
    step();
    clear_faults_i = 1'b0;
    chk("R4 clear in ara mode", int'(alert_no), 1);
    cfg_i = 8'h00;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_addr();
    t_fallback();
    t_rsvd();
    t_clear();
    t_default_mode();
    t_ara_mode();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule